// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many clock cycles. Results go into a dedicated pair of 32-bit registers, HI and LO, and not into the general register file. Commands arrive on a valid/ready channel. Each command carries a 3-bit operation code and two operands. Multiply and divide start a sequential engine that works for a fixed number of cycles. While the engine works, `busy` is high and the command channel refuses new work. The pipeline uses this refusal as its stall.

Four further commands give direct access to the register pair. Two copy an operand into HI or into LO. Two return the contents of HI or LO on a valid/ready response channel. The rules for back-pressure are as follows. A command is taken only on a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low while an operation is running and while a response is waiting. A response is held, unchanged, until the consumer raises `rsp_ready`.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset HI and LO read back as zero, `busy` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: Operation code 0 multiplies the operands as two's-complement values. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0.
- R3: Operation code 1 multiplies the operands as unsigned values, with the same split of the product between HI and LO.
- R4: Operation code 2 divides `cmd_a` by `cmd_b` as signed values. LO receives the quotient truncated toward zero. HI receives the remainder, which takes the sign of the dividend. The single overflow case (most negative value divided by -1) wraps the quotient to 0x80000000 and gives remainder 0.
- R5: Operation code 3 divides as unsigned values, with the quotient to LO and the remainder to HI.
- R6: A divide (code 2 or 3) whose divisor is zero finishes normally. It sets LO to all ones and HI to the unchanged dividend.
- R7: After a multiply or divide is taken, `busy` is high for exactly W+1 cycles (33 at default width), starting the cycle after acceptance. `cmd_ready` stays low for all of those cycles, so a move-from issued during that time stalls until the result is in HI/LO.
- R8: Operation code 6 loads `cmd_a` into HI and code 7 loads `cmd_a` into LO. The other register of the pair is left unchanged, `cmd_b` is ignored, and `busy` stays low.
- R9: Operation codes 4 (read HI) and 5 (read LO) raise `rsp_valid` in the cycle after acceptance, with the register value on `rsp_data`. Both stay stable until `rsp_ready` is high, and no command is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The unit takes the presented command this cycle |
| cmd_op | input | 3 | Operation code (see R2 to R9) |
| cmd_a | input | W | First operand: multiplicand, dividend, or the value to load |
| cmd_b | input | W | Second operand: multiplier or divisor |
| busy | output | 1 | A multiply or divide is in progress |
| rsp_valid | output | 1 | A move-from response is present |
| rsp_ready | input | 1 | The consumer takes the response |
| rsp_data | output | W | Contents of HI or LO |

## Verification
A command counts as taken at the first rising edge where `cmd_ready` is seen high while `cmd_valid` is high. A multiply or divide result cannot be observed until the following move-from has been taken, and that happens only after the 33-cycle busy window closes. So the bench counts busy cycles at falling edges from acceptance onward, then issues HI and LO reads. A read's data is due on `rsp_valid` one cycle after the read is taken. The bench samples it at the next falling edge and, in one directed case, holds `rsp_ready` low for several cycles to confirm that the data stays put.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_MULU = 3'd1,
    OP_DIV  = 3'd2,
    OP_DIVU = 3'd3,
    OP_RDHI = 3'd4,
    OP_RDLO = 3'd5,
    OP_WRHI = 3'd6,
    OP_WRLO = 3'd7
  } md_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_DIV  = 2'd2
  } md_state_e;
endpackage

// File: rtl/muldiv_mul_seq.sv
// Unsigned shift-add multiplier, one multiplier bit per cycle.
module muldiv_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic           busy_o,
  output logic [2*W-1:0] prod_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2*W-1:0] prod;
  logic [W-1:0]   mc;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [W:0]     sum;

  // Upper half plus the multiplicand when the current multiplier bit is set.
  assign sum = {1'b0, prod[2*W-1:W]} + (prod[0] ? {1'b0, mc} : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod <= '0;
      mc   <= '0;
      cnt  <= '0;
      run  <= 1'b0;
    end else if (start) begin
      prod <= {{W{1'b0}}, mplier_i};
      mc   <= mcand_i;
      cnt  <= '0;
      run  <= 1'b1;
    end else if (run) begin
      prod <= {sum, prod[W-1:1]};
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) run <= 1'b0;
    end
  end

  assign busy_o = run;
  assign prod_o = prod;
endmodule

// File: rtl/muldiv_div_seq.sv
// Unsigned restoring divider, one quotient bit per cycle.
module muldiv_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  quo;
  logic [W-1:0]  rem;
  logic [W-1:0]  dvs;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  assign shifted = {rem, quo[W-1]};
  assign diff    = shifted - {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo <= '0;
      rem <= '0;
      dvs <= '0;
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      quo <= dvd_i;
      rem <= '0;
      dvs <= dvs_i;
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (diff[W]) begin
        rem <= shifted[W-1:0];
        quo <= {quo[W-2:0], 1'b0};
      end else begin
        rem <= diff[W-1:0];
        quo <= {quo[W-2:0], 1'b1};
      end
      cnt <= cnt + 1'b1;
      if (cnt == LAST) run <= 1'b0;
    end
  end

  assign busy_o = run;
  assign quo_o  = quo;
  assign rem_o  = rem;
endmodule

// File: rtl/muldiv_hilo_regs.sv
module muldiv_hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hi_we,
  input  logic         lo_we,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_we) hi_q <= hi_d;
      if (lo_we) lo_q <= lo_d;
    end
  end
endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_a,
  input  logic [W-1:0] cmd_b,
  output logic         busy,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  md_state_e      state;
  md_op_e         op;
  logic           take;
  logic           is_signed;
  logic           a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;
  logic           mul_start, div_start;
  logic           mul_busy, div_busy;
  logic [2*W-1:0] mul_prod;
  logic [W-1:0]   div_quo, div_rem;

  // Sign bookkeeping captured at acceptance.
  logic           neg_prod, neg_quo, neg_rem, dz;
  logic [W-1:0]   dvd_raw;

  logic           hi_we, lo_we;
  logic [W-1:0]   hi_d, lo_d, hi_q, lo_q;
  logic [2*W-1:0] prod_fix;

  assign op        = md_op_e'(cmd_op);
  assign cmd_ready = (state == ST_IDLE) && !rsp_valid;
  assign busy      = (state != ST_IDLE);
  assign take      = cmd_valid && cmd_ready;

  assign is_signed = (op == OP_MUL) || (op == OP_DIV);
  assign a_neg     = is_signed && cmd_a[W-1];
  assign b_neg     = is_signed && cmd_b[W-1];
  assign a_mag     = a_neg ? -cmd_a : cmd_a;
  assign b_mag     = b_neg ? -cmd_b : cmd_b;

  assign mul_start = take && ((op == OP_MUL) || (op == OP_MULU));
  assign div_start = take && ((op == OP_DIV) || (op == OP_DIVU));

  muldiv_mul_seq #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mul_start),
    .mcand_i  (a_mag),
    .mplier_i (b_mag),
    .busy_o   (mul_busy),
    .prod_o   (mul_prod)
  );

  muldiv_div_seq #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (div_start),
    .dvd_i  (a_mag),
    .dvs_i  (b_mag),
    .busy_o (div_busy),
    .quo_o  (div_quo),
    .rem_o  (div_rem)
  );

  muldiv_hilo_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .hi_we (hi_we),
    .lo_we (lo_we),
    .hi_d  (hi_d),
    .lo_d  (lo_d),
    .hi_q  (hi_q),
    .lo_q  (lo_q)
  );

  assign prod_fix = neg_prod ? -mul_prod : mul_prod;

  // Write-back: a finished engine, or a move-to command.
  always_comb begin
    hi_we = 1'b0;
    lo_we = 1'b0;
    hi_d  = '0;
    lo_d  = '0;
    if (state == ST_MUL && !mul_busy) begin
      hi_we = 1'b1;
      lo_we = 1'b1;
      hi_d  = prod_fix[2*W-1:W];
      lo_d  = prod_fix[W-1:0];
    end else if (state == ST_DIV && !div_busy) begin
      hi_we = 1'b1;
      lo_we = 1'b1;
      if (dz) begin
        hi_d = dvd_raw;
        lo_d = '1;
      end else begin
        hi_d = neg_rem ? -div_rem : div_rem;
        lo_d = neg_quo ? -div_quo : div_quo;
      end
    end else if (take && op == OP_WRHI) begin
      hi_we = 1'b1;
      hi_d  = cmd_a;
    end else if (take && op == OP_WRLO) begin
      lo_we = 1'b1;
      lo_d  = cmd_a;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      neg_prod <= 1'b0;
      neg_quo  <= 1'b0;
      neg_rem  <= 1'b0;
      dz       <= 1'b0;
      dvd_raw  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (mul_start) begin
            neg_prod <= a_neg ^ b_neg;
            state    <= ST_MUL;
          end else if (div_start) begin
            neg_quo <= a_neg ^ b_neg;
            neg_rem <= a_neg;
            dz      <= (cmd_b == '0);
            dvd_raw <= cmd_a;
            state   <= ST_DIV;
          end
        end
        ST_MUL:  if (!mul_busy) state <= ST_IDLE;
        ST_DIV:  if (!div_busy) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Move-from response channel.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take && (op == OP_RDHI || op == OP_RDLO)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (op == OP_RDHI) ? hi_q : lo_q;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic         cmd_ready,
  input logic [2:0]   cmd_op,
  input logic         busy,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [W-1:0] rsp_data
);
  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] BUSY_LEN = CW'(W + 1);

  logic          took;
  logic [CW-1:0] bcnt;

  assign took = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)      bcnt <= '0;
    else if (took)   bcnt <= '0;
    else if (busy)   bcnt <= bcnt + 1'b1;
  end

  assert_busy_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  assert_arith_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (took && !cmd_op[2]) |=> busy);

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BUSY_LEN));

  assert_rsp_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op[2:1] == 2'b10) |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_rsp_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_move_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (took && cmd_op[2:1] == 2'b11) |=> !busy);
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data)
);

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = 3'd0;
  logic [W-1:0] cmd_a = '0;
  logic [W-1:0] cmd_b = '0;
  logic         busy;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic [W-1:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  muldiv_hilo #(.W(W)) i_muldiv_hilo (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_a     (cmd_a),
    .cmd_b     (cmd_b),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_mul(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    if (op == 3'd0) begin
      sa = $signed(a);
      sb = $signed(b);
      return 64'(sa * sb);
    end
    return {32'b0, a} * {32'b0, b};
  endfunction

  // Returns {HI, LO}.
  function automatic logic [63:0] exp_div(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    if (b == 32'd0) return {a, 32'hFFFF_FFFF};
    if (op == 3'd2) begin
      sa = $signed(a);
      sb = $signed(b);
      q  = sa / sb;
      r  = sa % sb;
      return {r[31:0], q[31:0]};
    end
    return {a % b, a / b};
  endfunction

  task automatic send(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_a     = a;
    cmd_b     = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] op, input int hold, output logic [31:0] data);
    send(op, 32'hDEAD_0000, 32'h0000_BEEF);
    @(negedge clk);
    check(rsp_valid === 1'b1, "R9 rsp_valid after read", {63'b0, rsp_valid}, 64'd1);
    data = rsp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(rsp_valid === 1'b1 && rsp_data === data && cmd_ready === 1'b0,
            "R9 response held", {31'b0, rsp_valid, rsp_data}, {31'b0, 1'b1, data});
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    #1 rsp_ready = 1'b0;
  endtask

  task automatic run_arith(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    int nb;
    logic [63:0] exp;
    logic [31:0] hi, lo;
    string tag;
    send(op, a, b);
    nb = 0;
    @(negedge clk);
    while (busy === 1'b1 && nb < 100) begin
      if (cmd_ready !== 1'b0) check(1'b0, "R7 ready low while busy", {63'b0, cmd_ready}, 64'd0);
      nb++;
      @(negedge clk);
    end
    check(nb == W + 1, "R7 busy length", 64'(nb), 64'(W + 1));
    if (op[1]) exp = exp_div(op, a, b);
    else       exp = exp_mul(op, a, b);
    case (op)
      3'd0: tag = "R2";
      3'd1: tag = "R3";
      3'd2: tag = (b == 0) ? "R6" : "R4";
      default: tag = (b == 0) ? "R6" : "R5";
    endcase
    read_reg(3'd4, 0, hi);
    read_reg(3'd5, 0, lo);
    check({hi, lo} === exp, tag, {hi, lo}, exp);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, w, a, b;
    logic [2:0]  op;
    int seed_sink;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && rsp_valid === 1'b0 && cmd_ready === 1'b1, "R1 idle after reset",
          {61'b0, busy, rsp_valid, cmd_ready}, 64'd1);
    read_reg(3'd4, 0, v);
    check(v === 32'd0, "R1 HI reset", {32'b0, v}, 64'd0);
    read_reg(3'd5, 0, v);
    check(v === 32'd0, "R1 LO reset", {32'b0, v}, 64'd0);

    // Directed corners
    run_arith(3'd0, 32'hFFFF_FFFF, 32'h0000_0002);   // R2: -1 * 2
    run_arith(3'd0, 32'h8000_0000, 32'h8000_0000);   // R2: min * min
    run_arith(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R3
    run_arith(3'd1, 32'd0, 32'h1234_5678);           // R3 zero
    run_arith(3'd2, 32'hFFFF_FFF9, 32'd2);           // R4: -7 / 2
    run_arith(3'd2, 32'd7, 32'hFFFF_FFFE);           // R4: 7 / -2
    run_arith(3'd2, 32'h8000_0000, 32'hFFFF_FFFF);   // R4: overflow case
    run_arith(3'd3, 32'hFFFF_FFFF, 32'd10);          // R5
    run_arith(3'd3, 32'd5, 32'hFFFF_FFF0);           // R5 divisor larger
    run_arith(3'd2, 32'hFFFF_FF00, 32'd0);           // R6 signed
    run_arith(3'd3, 32'h1357_9BDF, 32'd0);           // R6 unsigned

    // R8 move-to, cmd_b ignored, other register untouched
    send(3'd6, 32'hCAFE_F00D, 32'h1111_1111);
    @(negedge clk);
    check(busy === 1'b0, "R8 no busy on move-to", {63'b0, busy}, 64'd0);
    send(3'd7, 32'h0BAD_BEEF, 32'h2222_2222);
    read_reg(3'd4, 0, v);
    read_reg(3'd5, 0, w);
    check({v, w} === 64'hCAFE_F00D_0BAD_BEEF, "R8 move-to both", {v, w}, 64'hCAFE_F00D_0BAD_BEEF);
    send(3'd6, 32'h0000_0042, 32'hFFFF_FFFF);
    read_reg(3'd4, 0, v);
    read_reg(3'd5, 4, w);   // R9 hold with back-pressure
    check({v, w} === 64'h0000_0042_0BAD_BEEF, "R8 LO untouched by HI write", {v, w},
          64'h0000_0042_0BAD_BEEF);

    // R7 read issued during busy stalls until the product is in HI
    send(3'd1, 32'h0001_0000, 32'h0003_0000);
    @(negedge clk);
    check(cmd_ready === 1'b0, "R7 stall during busy", {63'b0, cmd_ready}, 64'd0);
    read_reg(3'd4, 0, v);
    check(v === 32'd3, "R7 read after busy sees result", {32'b0, v}, 64'd3);

    // Constrained random
    seed_sink = $urandom(32'd2024);
    for (int n = 0; n < 60; n++) begin
      op = 3'($urandom_range(0, 3));
      a  = $urandom();
      b  = $urandom();
      case ($urandom_range(0, 5))
        0: b = 32'd0;
        1: b = 32'($urandom_range(1, 9));
        2: a = 32'($urandom_range(0, 100));
        3: b = -32'($urandom_range(1, 9));
        default: ;
      endcase
      run_arith(op, a, b);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule